// File: doc/BRIEF.md
# Branch Target Buffer with Direction Counters

This block sits beside the fetch stage of a pipelined core. Every cycle the core presents the address it is fetching. The block compares that address against a small fully associative table of branch addresses it has seen taken before. When the address matches and the entry's 2-bit direction counter leans towards taken, the stored target comes back as the next fetch address in the same cycle. A correctly predicted taken branch therefore needs no bubble. In every other case the next fetch address is the sequential one (fetch address + 4).

Once a branch has executed, the core reports its address, whether it went, and where it went. The report arrives on the update port, which is accepted on every cycle in which it is valid. That port has no ready and applies no back-pressure, because the table can absorb one report per cycle. A report that matches an existing entry moves that entry's counter up or down, stopping at the ends. A taken report also refreshes the stored target. A report that misses the table creates an entry only when the branch was taken. The new entry uses a free slot if one exists, and otherwise evicts slots in round-robin order. Every change made by a report becomes visible to lookups from the following cycle on.

Top module: `btb_top`

## Requirements
- R1: After reset no entry is valid, so no lookup address produces a hit.
- R2: When `fetch_pc` matches a valid entry whose counter has its upper bit set (10 or 11), `pred_taken` is 1 and `next_pc` equals that entry's stored target in the same cycle.
- R3: On a lookup miss, or on a hit whose counter is 00 or 01, `pred_taken` is 0 and `next_pc` is `fetch_pc` + 4.
- R4: An update changes the table only at the clock edge that accepts it. A lookup of the same address in that same cycle sees the contents from before the update.
- R5: A not-taken update whose address is not in the table leaves the table unchanged.
- R6: A taken update whose address is not in the table allocates an entry with tag = `upd_pc`, target = `upd_target` and counter 11 (strongly taken).
- R7: Counter steps on a hit: +1 when taken and −1 when not taken. From 11, two consecutive not-taken updates are needed before the prediction turns to not taken.
- R8: The counter saturates. A taken update at 11 keeps it at 11, and a not-taken update at 00 keeps it at 00.
- R9: A taken update that hits overwrites the stored target with `upd_target`.
- R10: A not-taken update that hits leaves the stored target unchanged.
- R11: Allocation picks the lowest-numbered free slot. When all 8 slots are valid, allocation evicts slots in round-robin order starting at slot 0, and the pointer advances only on such evictions.
- R12: `pred_taken` is never 1 without `hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched this cycle |
| hit | output | 1 | `fetch_pc` matches a valid entry |
| pred_taken | output | 1 | Hit and counter predicts taken |
| next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch report is present this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | 32 | Resolved target address |

## Verification
A lookup and an update can occur in the same cycle, including the case where both name the same address. The bench provokes this by presenting an update and a lookup of the same address within one clock period. It samples the lookup before the edge and expects the pre-update result. It then samples again after the edge and expects the post-update result. Both expected values come from a table model kept in the bench. A further sweep interleaves reports over twelve addresses, enough to force evictions. After every report it probes all twelve addresses against that model, so lookups that follow an update closely are judged against what the update should have written.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] dir_ctr_t;

  localparam dir_ctr_t CTR_NEW = 2'b11;

  function automatic dir_ctr_t ctr_step(input dir_ctr_t cur, input logic went);
    dir_ctr_t nxt;
    nxt = cur;
    if (went && cur != 2'b11) nxt = cur + 2'b01;
    else if (!went && cur != 2'b00) nxt = cur - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/btb_cam.sv
module btb_cam #(
  parameter int N  = 8,
  parameter int AW = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vld,
  input  logic [AW-1:0] tags [N],
  input  logic [AW-1:0] key,
  output logic          found,
  output logic [IW-1:0] slot
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == key);
  end

  assign found = |match;

  always_comb begin
    slot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) slot = IW'(i);
    end
  end
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vld,
  input  logic          alloc,
  output logic [IW-1:0] victim
);
  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_slot;
  logic          full;

  assign full = &vld;

  always_comb begin
    free_slot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) free_slot = IW'(i);
    end
  end

  assign victim = full ? rr_q : free_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (alloc && full) begin
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/btb_top.sv
module btb_top #(
  parameter int N          = 8,
  parameter int AW         = 32,
  parameter int INST_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetch_pc,
  output logic          hit,
  output logic          pred_taken,
  output logic [AW-1:0] next_pc,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_pc,
  input  logic          upd_taken,
  input  logic [AW-1:0] upd_target
);
  import btb_pkg::*;

  localparam int IW = $clog2(N);
  localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

  logic [N-1:0]  vld_q;
  logic [AW-1:0] tag_q [N];
  logic [AW-1:0] tgt_q [N];
  dir_ctr_t      ctr_q [N];

  logic [IW-1:0] look_slot;
  logic          upd_hit;
  logic [IW-1:0] upd_slot;
  logic [IW-1:0] victim;
  logic          alloc;

  btb_cam #(.N(N), .AW(AW)) i_look_cam (
    .vld(vld_q), .tags(tag_q), .key(fetch_pc), .found(hit), .slot(look_slot)
  );

  btb_cam #(.N(N), .AW(AW)) i_upd_cam (
    .vld(vld_q), .tags(tag_q), .key(upd_pc), .found(upd_hit), .slot(upd_slot)
  );

  assign alloc = upd_valid && upd_taken && !upd_hit;

  btb_victim #(.N(N)) i_victim (
    .clk(clk), .rst_n(rst_n), .vld(vld_q), .alloc(alloc), .victim(victim)
  );

  assign pred_taken = hit && ctr_q[look_slot][1];
  assign next_pc    = pred_taken ? tgt_q[look_slot] : fetch_pc + STEP;

  for (genvar e = 0; e < N; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
        tag_q[e] <= '0;
        tgt_q[e] <= '0;
        ctr_q[e] <= '0;
      end else if (upd_valid && upd_hit && upd_slot == IW'(e)) begin
        ctr_q[e] <= ctr_step(ctr_q[e], upd_taken);
        if (upd_taken) tgt_q[e] <= upd_target;
      end else if (alloc && victim == IW'(e)) begin
        vld_q[e] <= 1'b1;
        tag_q[e] <= upd_pc;
        tgt_q[e] <= upd_target;
        ctr_q[e] <= CTR_NEW;
      end
    end
  end
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int N  = 8,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] fetch_pc,
  input logic          hit,
  input logic          pred_taken,
  input logic [AW-1:0] next_pc,
  input logic          upd_valid,
  input logic [AW-1:0] upd_pc,
  input logic          upd_taken,
  input logic [AW-1:0] upd_target,
  input logic          upd_hit,
  input logic [N-1:0]  vld
);
  // R12
  p_taken_needs_hit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> hit);

  // R3
  p_fallthrough_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> next_pc == fetch_pc + AW'(4));

  // R6
  p_new_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && !upd_hit) |=>
      (fetch_pc != $past(upd_pc)) || (pred_taken && next_pc == $past(upd_target)));

  // R5
  p_nt_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && !upd_hit) |=> $stable(vld));

  // R11
  p_valid_grow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) >= $countones($past(vld)));
endmodule

bind btb_top btb_checker #(.N(N), .AW(AW)) i_btb_checker (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .hit(hit),
  .pred_taken(pred_taken), .next_pc(next_pc), .upd_valid(upd_valid),
  .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
  .upd_hit(upd_hit), .vld(vld_q)
);

// File: tb/test_btb_top.sv
module test_btb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        hit, pred_taken;
  logic [31:0] next_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  btb_top i_btb_top (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .hit(hit),
    .pred_taken(pred_taken), .next_pc(next_pc), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
  );

  // bench-side table model, written from the requirements
  logic        m_vld [8];
  logic [31:0] m_tag [8];
  logic [31:0] m_tgt [8];
  logic [1:0]  m_ctr [8];
  int          m_rr;

  task automatic m_reset();
    for (int i = 0; i < 8; i++) begin
      m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 2'b00;
    end
    m_rr = 0;
  endtask

  task automatic m_look(input logic [31:0] pc, output logic h, output logic p,
                        output logic [31:0] n);
    h = 1'b0; p = 1'b0; n = pc + 32'd4;
    for (int i = 0; i < 8; i++) begin
      if (m_vld[i] && m_tag[i] == pc) begin
        h = 1'b1;
        if (m_ctr[i] >= 2'd2) begin p = 1'b1; n = m_tgt[i]; end
      end
    end
  endtask

  task automatic m_update(input logic [31:0] pc, input logic t, input logic [31:0] tg);
    int slot;
    int free;
    slot = -1;
    for (int i = 0; i < 8; i++) if (m_vld[i] && m_tag[i] == pc) slot = i;
    if (slot >= 0) begin
      if (t && m_ctr[slot] != 2'd3) m_ctr[slot] = m_ctr[slot] + 2'd1;
      if (!t && m_ctr[slot] != 2'd0) m_ctr[slot] = m_ctr[slot] - 2'd1;
      if (t) m_tgt[slot] = tg;
    end else if (t) begin
      free = -1;
      for (int i = 7; i >= 0; i--) if (!m_vld[i]) free = i;
      if (free < 0) begin
        free = m_rr;
        m_rr = (m_rr + 1) % 8;
      end
      m_vld[free] = 1'b1; m_tag[free] = pc; m_tgt[free] = tg; m_ctr[free] = 2'd3;
    end
  endtask

  task automatic cmp(input logic [31:0] pc, input string req);
    logic h, p;
    logic [31:0] n;
    m_look(pc, h, p, n);
    checks++;
    if (hit !== h) begin
      errors++;
      $display("FAIL %s hit pc=%h actual=%b expected=%b", req, pc, hit, h);
    end
    checks++;
    if (pred_taken !== p) begin
      errors++;
      $display("FAIL %s pred_taken pc=%h actual=%b expected=%b", req, pc, pred_taken, p);
    end
    checks++;
    if (next_pc !== n) begin
      errors++;
      $display("FAIL %s next_pc pc=%h actual=%h expected=%h", req, pc, next_pc, n);
    end
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    cmp(pc, req);
  endtask

  task automatic upd(input logic [31:0] pc, input logic t, input logic [31:0] tg);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_target = tg;
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    m_update(pc, t, tg);
  endtask

  function automatic logic [31:0] sweep_pc(input int k);
    return 32'h0000_4000 + 32'(k) * 32'd8;
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1, R3: empty table
    for (int k = 0; k < 4; k++) look(32'h100 + 32'(k) * 4, "R1");

    // R5: not-taken miss allocates nothing
    upd(32'h200, 1'b0, 32'h800);
    look(32'h200, "R5");

    // R6, R2: taken miss allocates strongly taken
    upd(32'h200, 1'b1, 32'h800);
    look(32'h200, "R6");

    // R4: update and lookup of the same address in one cycle
    @(negedge clk);
    fetch_pc = 32'h300;
    upd_valid = 1'b1; upd_pc = 32'h300; upd_taken = 1'b1; upd_target = 32'hA00;
    #1;
    cmp(32'h300, "R4");
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    m_update(32'h300, 1'b1, 32'hA00);
    cmp(32'h300, "R4");

    // R7: two not-taken needed to flip; R10 target kept
    upd(32'h200, 1'b0, 32'h0);
    look(32'h200, "R7");
    upd(32'h200, 1'b0, 32'h0);
    look(32'h200, "R7");
    upd(32'h200, 1'b1, 32'h800);
    look(32'h200, "R10");
    // R9: taken hit with a new target
    upd(32'h200, 1'b1, 32'h900);
    look(32'h200, "R9");
    // R8: saturate high then low
    upd(32'h200, 1'b1, 32'h900);
    upd(32'h200, 1'b0, 32'h0);
    look(32'h200, "R8");
    repeat (4) upd(32'h200, 1'b0, 32'h0);
    upd(32'h200, 1'b1, 32'h900);
    look(32'h200, "R8");

    // R11: fill the table, then evict in round-robin order
    for (int k = 0; k < 6; k++) upd(32'h1000 + 32'(k) * 4, 1'b1, 32'h5000 + 32'(k));
    for (int k = 0; k < 6; k++) look(32'h1000 + 32'(k) * 4, "R11");
    upd(32'h2000, 1'b1, 32'h6000);
    look(32'h200, "R11");
    look(32'h300, "R11");
    look(32'h2000, "R11");
    upd(32'h2004, 1'b1, 32'h6004);
    look(32'h300, "R11");
    look(32'h1000, "R11");

    // near-exhaustive mixed sweep over twelve addresses
    lfsr = 16'hACE1;
    for (int s = 0; s < 120; s++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      upd(sweep_pc(int'(lfsr[3:0]) % 12), lfsr[5] | lfsr[6],
          32'h9000 + 32'(lfsr[9:7]) * 16);
      for (int k = 0; k < 12; k++) look(sweep_pc(k), "R2");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule